// File: doc/BRIEF.md
# Register Window State Controller

This block keeps the bookkeeping state for a processor whose general registers are arranged as a ring of overlapping windows. It holds the current window pointer and four counters: windows free for a new frame (`cansave`), windows that hold a caller's frame (`canrestore`), windows owned by another address space (`otherwin`) and windows known to be clean (`cleanwin`). Four one-hot command strobes move this state. A frame push (save) or pop (restore) that cannot complete raises a one-cycle spill or fill request for the trap logic. The completion notices `saved` and `restored` tell the block that a handler has moved a window out to memory or back in.

Software reaches the state through a register port with a 3-bit select, a write enable and a combinational read. The same port also returns a read-only version word that carries the physical window count and the deepest trap level, a window-state word that is split into two subfields, and a tick-access control bit. The counters `cansave`, `canrestore` and `otherwin` must always add up to the window count minus two. The block watches this sum at all times and raises a flag whenever a direct write breaks it. Elaboration stops with an error when the configured window count is below three or above the number of physical windows.

Every pin is a plain control or status signal. No data stream crosses the boundary, so the block has no valid/ready handshake and never applies back-pressure. A command is consumed in the cycle in which its strobe is high.

Top module: `rwin_state_ctrl`

## Requirements
- R1: After reset the window pointer is 0, `cansave` is NWIN-2, `canrestore` is 0, `otherwin` is 0, `cleanwin` is 1 and the window-state word is 0. The tick-access bit reads 1, which means user-mode reads of the tick counter are blocked.
- R2: `inconsistent_o` is high exactly when `cansave`+`canrestore`+`otherwin` differs from NWIN-2. Commands never break the sum; only direct writes can.
- R3: A save with `cansave`=0 leaves all state unchanged and pulses `spill_req_o` high for one cycle, one clock after the command. Any other save advances the pointer by one modulo NWIN, decrements `cansave` and increments `canrestore`.
- R4: A restore with `canrestore`=0 leaves all state unchanged and pulses `fill_req_o` one clock after the command. Any other restore moves the pointer back by one modulo NWIN, decrements `canrestore` and increments `cansave`.
- R5: `saved` increments `cansave` and decrements `otherwin` when `otherwin` is nonzero. Otherwise it decrements `canrestore`. It has no effect when both are zero.
- R6: `restored` increments `canrestore` and decrements `otherwin` when `otherwin` is nonzero. Otherwise it decrements `cansave`. It has no effect when both are zero. When it takes effect it also increments `cleanwin`, saturating at NWIN-1.
- R7: A register write lands on the next clock edge. In a write cycle every command strobe is ignored: no counter or pointer moves and no spill or fill request is raised.
- R8: When more than one command strobe is high in the same cycle, nothing changes and no request is raised.
- R9: Select codes: 0 pointer, 1 `cansave`, 2 `canrestore`, 3 `otherwin`, 4 `cleanwin`, 5 window-state, 6 version, 7 tick-access (bit 0). Reads are zero-extended. Writes to code 6 are ignored. The version word is PHYS_WIN ORed with MAX_TL shifted left by TL_SHIFT, which is 0x0508 with the default parameters.
- R10: The window-state word keeps its "normal" subfield in bits [WS_W-1:0] and its "other" subfield in bits [2*WS_W-1:WS_W]. Each subfield appears on its own output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_i | input | 1 | Save command strobe |
| restore_i | input | 1 | Restore command strobe |
| saved_i | input | 1 | Window-spilled completion strobe |
| restored_i | input | 1 | Window-filled completion strobe |
| wr_en_i | input | 1 | Register write enable |
| sel_i | input | 3 | Register select |
| wdata_i | input | DW | Register write data |
| rdata_o | output | DW | Register read data (combinational) |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| spill_req_o | output | 1 | One-cycle spill trap request |
| fill_req_o | output | 1 | One-cycle fill trap request |
| inconsistent_o | output | 1 | Counter sum differs from NWIN-2 |
| wstate_normal_o | output | WS_W | Normal subfield of the window-state word |
| wstate_other_o | output | WS_W | Other subfield of the window-state word |
| tick_user_blocked_o | output | 1 | User-mode tick reads are blocked |

## Verification
The hardest states to reach from the ports are those with `otherwin` nonzero. No command ever raises `otherwin`, so the `saved` and `restored` branches that use it are never exercised on their own. The bench therefore writes consistent splits of NWIN-2 across the three counters, then runs a long pseudo-random command stream against an arithmetic model, writing a new split at intervals. The spill and fill edges are reached by running the pointer around the ring until `cansave` or `canrestore` is exhausted. The flag behaviour is swept by writing every `cansave` value against several `otherwin` values.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam logic [2:0] SEL_CWP        = 3'd0;
  localparam logic [2:0] SEL_CANSAVE    = 3'd1;
  localparam logic [2:0] SEL_CANRESTORE = 3'd2;
  localparam logic [2:0] SEL_OTHERWIN   = 3'd3;
  localparam logic [2:0] SEL_CLEANWIN   = 3'd4;
  localparam logic [2:0] SEL_WSTATE     = 3'd5;
  localparam logic [2:0] SEL_VERSION    = 3'd6;
  localparam logic [2:0] SEL_TICKCTL    = 3'd7;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SAVE,
    OP_RESTORE,
    OP_SAVED,
    OP_RESTORED
  } rwin_op_e;
endpackage

// File: rtl/rwin_op_decode.sv
module rwin_op_decode
  import rwin_pkg::*;
(
  input  logic     save_i,
  input  logic     restore_i,
  input  logic     saved_i,
  input  logic     restored_i,
  input  logic     hold_i,
  output rwin_op_e op_o
);
  logic [3:0] strobes;
  logic       single;

  assign strobes = {restored_i, saved_i, restore_i, save_i};
  // exactly one strobe: nonzero and clearing the lowest set bit leaves zero
  assign single  = (strobes != 4'd0) && ((strobes & (strobes - 4'd1)) == 4'd0);

  always_comb begin
    op_o = OP_NONE;
    if (single && !hold_i) begin
      if (save_i)         op_o = OP_SAVE;
      else if (restore_i) op_o = OP_RESTORE;
      else if (saved_i)   op_o = OP_SAVED;
      else                op_o = OP_RESTORED;
    end
  end
endmodule

// File: rtl/rwin_next.sv
module rwin_next
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  rwin_op_e         op_i,
  input  logic [CW-1:0]    cwp_i,
  input  logic [CW-1:0]    cansave_i,
  input  logic [CW-1:0]    canrestore_i,
  input  logic [CW-1:0]    otherwin_i,
  input  logic [CW-1:0]    cleanwin_i,
  output logic [CW-1:0]    cwp_o,
  output logic [CW-1:0]    cansave_o,
  output logic [CW-1:0]    canrestore_o,
  output logic [CW-1:0]    otherwin_o,
  output logic [CW-1:0]    cleanwin_o,
  output logic             spill_o,
  output logic             fill_o
);
  localparam logic [CW-1:0] LAST_WIN  = CW'(NWIN - 1);
  localparam logic [CW-1:0] CLEAN_MAX = CW'(NWIN - 1);

  logic clean_bump;

  always_comb begin
    cwp_o        = cwp_i;
    cansave_o    = cansave_i;
    canrestore_o = canrestore_i;
    otherwin_o   = otherwin_i;
    cleanwin_o   = cleanwin_i;
    spill_o      = 1'b0;
    fill_o       = 1'b0;
    clean_bump   = 1'b0;
    case (op_i)
      OP_SAVE: begin
        if (cansave_i == '0) spill_o = 1'b1;
        else begin
          cwp_o        = (cwp_i == LAST_WIN) ? '0 : cwp_i + 1'b1;
          cansave_o    = cansave_i - 1'b1;
          canrestore_o = canrestore_i + 1'b1;
        end
      end
      OP_RESTORE: begin
        if (canrestore_i == '0) fill_o = 1'b1;
        else begin
          cwp_o        = (cwp_i == '0) ? LAST_WIN : cwp_i - 1'b1;
          canrestore_o = canrestore_i - 1'b1;
          cansave_o    = cansave_i + 1'b1;
        end
      end
      OP_SAVED: begin
        if (otherwin_i != '0) begin
          cansave_o  = cansave_i + 1'b1;
          otherwin_o = otherwin_i - 1'b1;
        end else if (canrestore_i != '0) begin
          cansave_o    = cansave_i + 1'b1;
          canrestore_o = canrestore_i - 1'b1;
        end
      end
      OP_RESTORED: begin
        if (otherwin_i != '0) begin
          canrestore_o = canrestore_i + 1'b1;
          otherwin_o   = otherwin_i - 1'b1;
          clean_bump   = 1'b1;
        end else if (cansave_i != '0) begin
          canrestore_o = canrestore_i + 1'b1;
          cansave_o    = cansave_i - 1'b1;
          clean_bump   = 1'b1;
        end
        if (clean_bump && cleanwin_i < CLEAN_MAX) cleanwin_o = cleanwin_i + 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rwin_readmux.sv
module rwin_readmux
  import rwin_pkg::*;
#(
  parameter int NWIN     = 8,
  parameter int PHYS_WIN = 8,
  parameter int MAX_TL   = 5,
  parameter int TL_SHIFT = 8,
  parameter int DW       = 16,
  parameter int WS_W     = 3,
  localparam int CW = $clog2(NWIN)
) (
  input  logic [2:0]        sel_i,
  input  logic [CW-1:0]     cwp_i,
  input  logic [CW-1:0]     cansave_i,
  input  logic [CW-1:0]     canrestore_i,
  input  logic [CW-1:0]     otherwin_i,
  input  logic [CW-1:0]     cleanwin_i,
  input  logic [2*WS_W-1:0] wstate_i,
  input  logic              tick_blk_i,
  output logic [DW-1:0]     rdata_o
);
  localparam logic [DW-1:0] VERSION_WORD =
    DW'(PHYS_WIN) | (DW'(MAX_TL) << TL_SHIFT);

  always_comb begin
    case (sel_i)
      SEL_CWP:        rdata_o = DW'(cwp_i);
      SEL_CANSAVE:    rdata_o = DW'(cansave_i);
      SEL_CANRESTORE: rdata_o = DW'(canrestore_i);
      SEL_OTHERWIN:   rdata_o = DW'(otherwin_i);
      SEL_CLEANWIN:   rdata_o = DW'(cleanwin_i);
      SEL_WSTATE:     rdata_o = DW'(wstate_i);
      SEL_VERSION:    rdata_o = VERSION_WORD;
      default:        rdata_o = DW'(tick_blk_i);
    endcase
  end
endmodule

// File: rtl/rwin_state_ctrl.sv
module rwin_state_ctrl
  import rwin_pkg::*;
#(
  parameter int NWIN     = 8,
  parameter int PHYS_WIN = 8,
  parameter int MAX_TL   = 5,
  parameter int TL_SHIFT = 8,
  parameter int DW       = 16,
  parameter int WS_W     = 3,
  localparam int CW = $clog2(NWIN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            saved_i,
  input  logic            restored_i,
  input  logic            wr_en_i,
  input  logic [2:0]      sel_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [CW-1:0]   cwp_o,
  output logic            spill_req_o,
  output logic            fill_req_o,
  output logic            inconsistent_o,
  output logic [WS_W-1:0] wstate_normal_o,
  output logic [WS_W-1:0] wstate_other_o,
  output logic            tick_user_blocked_o
);
  localparam int SW = CW + 2;
  localparam logic [SW-1:0] SUM_TARGET = SW'(NWIN - 2);

  if (NWIN > PHYS_WIN || NWIN < 3) begin : g_bad_cfg
    $error("rwin_state_ctrl: window count outside 3..PHYS_WIN");
  end

  rwin_op_e          op;
  logic [CW-1:0]     cwp_q, cansave_q, canrestore_q, otherwin_q, cleanwin_q;
  logic [CW-1:0]     cwp_n, cansave_n, canrestore_n, otherwin_n, cleanwin_n;
  logic [2*WS_W-1:0] wstate_q;
  logic              tick_blk_q, spill_q, fill_q, spill_n, fill_n;
  logic [SW-1:0]     win_sum;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  rwin_op_decode u_decode (
    .save_i     (save_i),
    .restore_i  (restore_i),
    .saved_i    (saved_i),
    .restored_i (restored_i),
    .hold_i     (wr_en_i),
    .op_o       (op)
  );

  rwin_next #(.NWIN(NWIN)) u_next (
    .op_i         (op),
    .cwp_i        (cwp_q),
    .cansave_i    (cansave_q),
    .canrestore_i (canrestore_q),
    .otherwin_i   (otherwin_q),
    .cleanwin_i   (cleanwin_q),
    .cwp_o        (cwp_n),
    .cansave_o    (cansave_n),
    .canrestore_o (canrestore_n),
    .otherwin_o   (otherwin_n),
    .cleanwin_o   (cleanwin_n),
    .spill_o      (spill_n),
    .fill_o       (fill_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q        <= '0;
      cansave_q    <= CW'(NWIN - 2);
      canrestore_q <= '0;
      otherwin_q   <= '0;
      cleanwin_q   <= CW'(1);
      wstate_q     <= '0;
      tick_blk_q   <= 1'b1;
      spill_q      <= 1'b0;
      fill_q       <= 1'b0;
    end else begin
      spill_q <= spill_n;
      fill_q  <= fill_n;
      if (wr_en_i) begin
        case (sel_i)
          SEL_CWP:        cwp_q        <= wdata_i[CW-1:0];
          SEL_CANSAVE:    cansave_q    <= wdata_i[CW-1:0];
          SEL_CANRESTORE: canrestore_q <= wdata_i[CW-1:0];
          SEL_OTHERWIN:   otherwin_q   <= wdata_i[CW-1:0];
          SEL_CLEANWIN:   cleanwin_q   <= wdata_i[CW-1:0];
          SEL_WSTATE:     wstate_q     <= wdata_i[2*WS_W-1:0];
          SEL_TICKCTL:    tick_blk_q   <= wdata_i[0];
          default: ;
        endcase
      end else begin
        cwp_q        <= cwp_n;
        cansave_q    <= cansave_n;
        canrestore_q <= canrestore_n;
        otherwin_q   <= otherwin_n;
        cleanwin_q   <= cleanwin_n;
      end
    end
  end

  assign win_sum = SW'(cansave_q) + SW'(canrestore_q) + SW'(otherwin_q);
  assign inconsistent_o      = (win_sum != SUM_TARGET);
  assign cwp_o               = cwp_q;
  assign spill_req_o         = spill_q;
  assign fill_req_o          = fill_q;
  assign tick_user_blocked_o = tick_blk_q;
  assign wstate_normal_o     = wstate_q[WS_W-1:0];
  assign wstate_other_o      = wstate_q[2*WS_W-1:WS_W];

  rwin_readmux #(
    .NWIN(NWIN), .PHYS_WIN(PHYS_WIN), .MAX_TL(MAX_TL),
    .TL_SHIFT(TL_SHIFT), .DW(DW), .WS_W(WS_W)
  ) u_rd (
    .sel_i        (sel_i),
    .cwp_i        (cwp_q),
    .cansave_i    (cansave_q),
    .canrestore_i (canrestore_q),
    .otherwin_i   (otherwin_q),
    .cleanwin_i   (cleanwin_q),
    .wstate_i     (wstate_q),
    .tick_blk_i   (tick_blk_q),
    .rdata_o      (rdata_o)
  );

  assert_spill_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !restore_i && !saved_i && !restored_i && !wr_en_i && cansave_q == '0)
    |=> (spill_req_o && $stable(cwp_q) && $stable(canrestore_q)));

  assert_save_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !restore_i && !saved_i && !restored_i && !wr_en_i && cansave_q != '0)
    |=> (cansave_q == $past(cansave_q) - 1'b1 && !spill_req_o));

  assert_fill_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !saved_i && !restored_i && !wr_en_i && canrestore_q == '0)
    |=> (fill_req_o && $stable(cwp_q) && $stable(cansave_q)));

  assert_wr_prio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_CANSAVE)
    |=> (cansave_q == $past(wdata_i[CW-1:0]) && !spill_req_o && !fill_req_o));

  assert_sum_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inconsistent_o && !wr_en_i) |=> !inconsistent_o);

  assert_multi_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({save_i, restore_i, saved_i, restored_i}) > 1 && !wr_en_i)
    |=> ($stable(cwp_q) && $stable(cansave_q) && $stable(otherwin_q) && !spill_req_o && !fill_req_o));
endmodule

// File: tb/rwin_state_ctrl_tb.sv
`timescale 1ns/1ps
module rwin_state_ctrl_tb_top;
  localparam int NW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sv = 0, rs = 0, svd = 0, rsd = 0, wr = 0;
  logic [2:0]    sel = 0;
  logic [DW-1:0] wd = 0;
  logic [DW-1:0] rd;
  logic [2:0]    cwp;
  logic          spill, fill, inc, tblk;
  logic [2:0]    wsn, wso;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  int m_cwp, m_cs, m_cr, m_ow, m_cw;
  int e_spill, e_fill;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  rwin_state_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .save_i(sv), .restore_i(rs), .saved_i(svd),
    .restored_i(rsd), .wr_en_i(wr), .sel_i(sel), .wdata_i(wd), .rdata_o(rd),
    .cwp_o(cwp), .spill_req_o(spill), .fill_req_o(fill), .inconsistent_o(inc),
    .wstate_normal_o(wsn), .wstate_other_o(wso), .tick_user_blocked_o(tblk)
  );

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [2:0] s, output int v);
    sel = s;
    #0.5;
    v = int'(rd);
  endtask

  task automatic check_state(string tag);
    int v;
    read_reg(3'd0, v); check({tag, " cwp"}, v, m_cwp);
    check({tag, " cwp_o"}, int'(cwp), m_cwp);
    read_reg(3'd1, v); check({tag, " cansave"}, v, m_cs);
    read_reg(3'd2, v); check({tag, " canrestore"}, v, m_cr);
    read_reg(3'd3, v); check({tag, " otherwin"}, v, m_ow);
    read_reg(3'd4, v); check({tag, " cleanwin"}, v, m_cw);
    check({tag, " inconsistent R2"}, int'(inc), int'(m_cs + m_cr + m_ow != NW - 2));
  endtask

  // kind: 0 save, 1 restore, 2 saved, 3 restored, 4 save+restore together
  task automatic do_cmd(int kind, string tag);
    @(negedge clk);
    sv = (kind == 0 || kind == 4); rs = (kind == 1 || kind == 4);
    svd = (kind == 2); rsd = (kind == 3);
    e_spill = 0; e_fill = 0;
    case (kind)
      0: if (m_cs == 0) e_spill = 1;
         else begin m_cwp = (m_cwp + 1) % NW; m_cs--; m_cr++; end
      1: if (m_cr == 0) e_fill = 1;
         else begin m_cwp = (m_cwp + NW - 1) % NW; m_cr--; m_cs++; end
      2: if (m_ow != 0) begin m_cs++; m_ow--; end
         else if (m_cr != 0) begin m_cs++; m_cr--; end
      3: begin
           bit eff = 0;
           if (m_ow != 0) begin m_cr++; m_ow--; eff = 1; end
           else if (m_cs != 0) begin m_cr++; m_cs--; eff = 1; end
           if (eff && m_cw < NW - 1) m_cw++;
         end
      default: ;
    endcase
    @(negedge clk);
    sv = 0; rs = 0; svd = 0; rsd = 0;
    check({tag, " spill"}, int'(spill), e_spill);
    check({tag, " fill"}, int'(fill), e_fill);
    check_state(tag);
  endtask

  task automatic write_reg(logic [2:0] s, int v, bit with_save);
    @(negedge clk);
    wr = 1; sel = s; wd = DW'(v); sv = with_save;
    case (s)
      3'd0: m_cwp = v % NW;
      3'd1: m_cs = v % NW;
      3'd2: m_cr = v % NW;
      3'd3: m_ow = v % NW;
      3'd4: m_cw = v % NW;
      default: ;
    endcase
    @(negedge clk);
    wr = 0; sv = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int v;
    m_cwp = 0; m_cs = NW - 2; m_cr = 0; m_ow = 0; m_cw = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_state("R1 reset");
    read_reg(3'd5, v); check("R1 wstate reset", v, 0);
    read_reg(3'd7, v); check("R1 tick blocked", v, 1);
    check("R1 tick port", int'(tblk), 1);
    // R9 version word
    read_reg(3'd6, v); check("R9 version", v, 16'h0508);

    // R3 walk forward to spill
    for (int i = 0; i < NW - 1; i++) do_cmd(0, "R3 save walk");
    do_cmd(0, "R3 save at zero");
    // R4 walk back to fill
    for (int i = 0; i < NW - 1; i++) do_cmd(1, "R4 restore walk");
    // R4 pointer wrap below zero: build frames from pointer 0 after forced cwp
    write_reg(3'd0, 1, 0);
    do_cmd(0, "R3 advance"); do_cmd(1, "R4 back"); do_cmd(1, "R4 fill at zero");
    write_reg(3'd0, 0, 0);
    do_cmd(0, "R3 from 0"); write_reg(3'd0, 0, 0); do_cmd(1, "R4 wrap to last");

    // R8 two strobes at once
    do_cmd(4, "R8 double strobe");

    // R5/R6 pseudo-random sweep over consistent splits
    for (int blk = 0; blk < 8; blk++) begin
      int ow0 = blk % 4;
      int cr0 = (blk / 2) % (NW - 1 - ow0);
      write_reg(3'd3, ow0, 0);
      write_reg(3'd2, cr0, 0);
      write_reg(3'd1, NW - 2 - ow0 - cr0, 0);
      check_state("R5 R6 split load");
      for (int k = 0; k < 400; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[7:0] == 8'h3C) do_cmd(4, "R8 random double");
        else if (lfsr[1:0] == 2'd2) do_cmd(2, "R5 saved");
        else if (lfsr[1:0] == 2'd3) do_cmd(3, "R6 restored");
        else do_cmd(int'(lfsr[1:0]), "R3 R4 random");
      end
    end

    // R6 cleanwin saturation
    write_reg(3'd4, NW - 2, 0);
    write_reg(3'd3, 0, 0); write_reg(3'd2, 0, 0); write_reg(3'd1, NW - 2, 0);
    do_cmd(3, "R6 clean to max"); do_cmd(3, "R6 clean saturate");

    // R7 write beats a save, including a save that would spill
    write_reg(3'd1, 2, 1);
    check_state("R7 write over save");
    write_reg(3'd1, 0, 0);
    @(negedge clk); wr = 1; sel = 3'd3; wd = 16'd5; sv = 1; m_ow = 5;
    @(negedge clk); wr = 0; sv = 0;
    check("R7 no spill during write", int'(spill), 0);
    check_state("R7 otherwin written");

    // R2 flag sweep
    for (int a = 0; a < NW; a++)
      for (int b = 0; b < 4; b++) begin
        write_reg(3'd1, a, 0); write_reg(3'd3, b, 0);
        check_state("R2 sweep");
      end

    // R10 wstate subfields
    for (int w = 0; w < 64; w++) begin
      write_reg(3'd5, w, 0);
      check("R10 normal", int'(wsn), w & 7);
      check("R10 other", int'(wso), w >> 3);
      read_reg(3'd5, v); check("R10 readback", v, w);
    end

    // R9 version not writable; tick bit writable
    write_reg(3'd6, 16'hFFFF, 0);
    read_reg(3'd6, v); check("R9 version after write", v, 16'h0508);
    write_reg(3'd7, 0, 0);
    read_reg(3'd7, v); check("R9 tick cleared", v, 0);
    check("R9 tick port", int'(tblk), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule